// File: doc/BRIEF.md
# Random Generator Register Front-End

This block is the register-mapped face of a seeded pseudo-random generator. Software writes a command code to a control register to reseed the generator or to ask for fresh output. It polls or takes an interrupt when the operation is done, then reads up to eight 32-bit output words. A 32-bit shift register with linear feedback stands in for a physical entropy source. Its seed comes from the `seed_in` port, so results are repeatable.

Output can only be produced once a reseed has brought the generator into the seeded state. A request made earlier is refused and flagged. Completion events, refusals and a degenerate all-zero generator state are recorded as sticky status bits that software clears by writing ones. Each source has its own enable, and a global enable sits over all of them and drives a level interrupt output. Features and build configuration read back as fixed, parameter-set words.

Top module: `rng_regfront`

## Requirements
- R1: After reset, the status word (0x04), interrupt status (0x14), interrupt enables (0x10), mode (0x08) and every output word (0x20..0x3C) read 0, and `irq` is low.
- R2: A write to 0x00 takes a command from bits 1:0: 0 does nothing, 1 requests output, 2 reseeds from `seed_in`, 3 reseeds from `seed_in` XOR 32'h5A5A_5A5A. The seed is taken on the completing edge.
- R3: A reseed completes on the 8th rising edge after the edge that accepted it. From then on, bit 9 of 0x04 reads 1 and stays 1, and interrupt status bit 1 (seed done) is set.
- R4: An output request made while seeded completes on the 4th rising edge after it was accepted and sets interrupt status bit 0 (random ready).
- R5: The generator state S steps as S' = {S[30:0], S[31]^S[21]^S[1]^S[0]}. Output word i (at 0x20+4*i) receives S after i+1 steps. The state then advances by 8 steps, or by 4 in short mode.
- R6: Bit 3 of 0x08 (readable back, other bits read 0) selects 256-bit output. When it is clear, only words 0..3 are refreshed, words 4..7 keep their values, and the state advances 4 steps. The length is taken at completion.
- R7: An output request made while unseeded sets interrupt status bit 3 (request lockup) on the accepting edge, starts nothing, and never sets bit 0.
- R8: A command written while a reseed or output request is in progress, including on its completing edge, is ignored.
- R9: Interrupt status at 0x14 holds bits 4..0 = generator lockup, request lockup, age alarm (no source, reads 0), seed done, random ready. Writing 1 to a bit clears it. A hardware set on the same edge wins over the clear.
- R10: 0x10 holds the global enable in bit 31 and per-source enables in bits 4..0 (other bits read 0). `irq` is high exactly when bit 31 is set and some status bit is set with its enable set.
- R11: If the generator state is ever all zeros, on the next edge it is forced to 32'h0000_0001 and interrupt status bit 4 is set.
- R12: 0x1C reads 32'h0000_000D (max length code 1 in bits 1:0, seed source present in bit 2, mission mode after reset in bit 3). 0x18 reads 32'h0000_0038, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| seed_in | input | 32 | Seed value used by a reseed |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong completion counter shows as a status bit 1 or 0 arriving one edge early or late. The bench probes the edge before and the edge of completion to catch this. A corrupted generator state, or a wrongly mixed nonce, shows in the next output read as words that differ from the stepped seed. A lockup that is not repaired leaves all-zero words and an unset bit 4 one edge after the zero load. Errors in enable or clear logic show immediately on `irq` and on the readback of 0x14.

// File: rtl/rngf_pkg.sv
package rngf_pkg;
    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] NONCE_MIX = 32'h5A5A_5A5A;
    localparam logic [WORD_W-1:0] LOCK_FILL = 32'h0000_0001;

    // interrupt source positions (decoded by software)
    localparam int SRC_RDY  = 0;
    localparam int SRC_SEED = 1;
    localparam int SRC_AGE  = 2;
    localparam int SRC_REQ  = 3;
    localparam int SRC_LOCK = 4;
    localparam int NSRC     = 5;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_FILL   = 2'd1,
        OP_SEED   = 2'd2,
        OP_NONCE  = 2'd3
    } op_e;

    function automatic logic [WORD_W-1:0] gen_step(input logic [WORD_W-1:0] s);
        return {s[WORD_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction
endpackage

// File: rtl/rngf_lfsr.sv
module rngf_lfsr
    import rngf_pkg::*;
#(
    parameter int NWORDS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [WORD_W-1:0]             load_val,
    input  logic                          adv,
    input  logic                          adv_full,
    output logic [WORD_W-1:0]             state,
    output logic [NWORDS-1:0][WORD_W-1:0] words,
    output logic                          lock_evt
);
    localparam int HALF = NWORDS / 2;

    logic [WORD_W-1:0] state_d, state_q;
    logic [WORD_W-1:0] chain [0:NWORDS];

    always_comb begin
        chain[0] = state_q;
        for (int i = 0; i < NWORDS; i++) begin
            chain[i+1] = gen_step(chain[i]);
            words[i]   = chain[i+1];
        end
        lock_evt = (state_q == '0);
        state_d  = state_q;
        if (load)
            state_d = load_val;
        else if (lock_evt)
            state_d = LOCK_FILL;
        else if (adv)
            state_d = adv_full ? chain[NWORDS] : chain[HALF];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LOCK_FILL;
        else        state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/rngf_irq.sv
module rngf_irq
    import rngf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ie_we,
    input  logic            is_we,
    input  logic            glob_wr,
    input  logic [NSRC-1:0] src_wr,
    input  logic [NSRC-1:0] set_vec,
    output logic            ie_glob,
    output logic [NSRC-1:0] ie_src,
    output logic [NSRC-1:0] is_vec,
    output logic            irq
);
    typedef struct packed {
        logic            glob;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] stat;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ie_we) begin
            st_d.glob = glob_wr;
            st_d.en   = src_wr;
        end
        // clear first, then set: a set on the same edge wins
        if (is_we)
            st_d.stat = st_q.stat & ~src_wr;
        st_d.stat = st_d.stat | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ie_glob = st_q.glob;
    assign ie_src  = st_q.en;
    assign is_vec  = st_q.stat;
    assign irq     = st_q.glob && ((st_q.stat & st_q.en) != '0);
endmodule

// File: rtl/rng_regfront.sv
module rng_regfront
    import rngf_pkg::*;
#(
    parameter int          NWORDS       = 8,
    parameter int          RESEED_CYC   = 8,
    parameter int          FILL_CYC     = 4,
    parameter logic [31:0] FEATURE_WORD = 32'h0000_000D,
    parameter logic [31:0] BUILD_WORD   = 32'h0000_0038
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] seed_in,
    output logic        irq
);
    localparam int CNT_W = $clog2(RESEED_CYC + 1);
    localparam int IDX_W = $clog2(NWORDS);
    localparam int HALF  = NWORDS / 2;

    localparam logic [7:0] A_CMD  = 8'h00;
    localparam logic [7:0] A_STAT = 8'h04;
    localparam logic [7:0] A_MODE = 8'h08;
    localparam logic [7:0] A_IE   = 8'h10;
    localparam logic [7:0] A_IS   = 8'h14;
    localparam logic [7:0] A_BLD  = 8'h18;
    localparam logic [7:0] A_FEAT = 8'h1C;
    localparam logic [7:0] A_DATA = 8'h20;

    typedef struct packed {
        logic [CNT_W-1:0]                 cnt;
        op_e                              op;
        logic                             seeded;
        logic                             len256;
        logic [NWORDS-1:0][WORD_W-1:0]    data;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NSRC-1:0]                  set_vec;
    logic                             gen_load, gen_adv, lock_evt;
    logic [WORD_W-1:0]                gen_seed, lfsr_state;
    logic [NWORDS-1:0][WORD_W-1:0]    gen_words;
    logic                             ie_glob;
    logic [NSRC-1:0]                  ie_src, is_vec;
    logic                             cmd_hit;
    op_e                              cmd;

    assign cmd_hit = bus_we && (bus_addr == A_CMD);
    assign cmd     = op_e'(bus_wdata[1:0]);

    always_comb begin
        st_d     = st_q;
        set_vec  = '0;
        gen_load = 1'b0;
        gen_adv  = 1'b0;
        gen_seed = (st_q.op == OP_NONCE) ? (seed_in ^ NONCE_MIX) : seed_in;
        set_vec[SRC_LOCK] = lock_evt;

        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.op = OP_IDLE;
                if (st_q.op == OP_FILL) begin
                    gen_adv = 1'b1;
                    set_vec[SRC_RDY] = 1'b1;
                    for (int i = 0; i < NWORDS; i++)
                        if (st_q.len256 || i < HALF)
                            st_d.data[i] = gen_words[i];
                end else begin
                    gen_load = 1'b1;
                    st_d.seeded = 1'b1;
                    set_vec[SRC_SEED] = 1'b1;
                end
            end
        end else if (cmd_hit) begin
            unique case (cmd)
                OP_FILL: begin
                    if (st_q.seeded) begin
                        st_d.cnt = CNT_W'(FILL_CYC);
                        st_d.op  = OP_FILL;
                    end else begin
                        set_vec[SRC_REQ] = 1'b1;
                    end
                end
                OP_SEED, OP_NONCE: begin
                    st_d.cnt = CNT_W'(RESEED_CYC);
                    st_d.op  = cmd;
                end
                default: ;
            endcase
        end

        if (bus_we && bus_addr == A_MODE)
            st_d.len256 = bus_wdata[3];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rngf_lfsr #(.NWORDS(NWORDS)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gen_load),
        .load_val (gen_seed),
        .adv      (gen_adv),
        .adv_full (st_q.len256),
        .state    (lfsr_state),
        .words    (gen_words),
        .lock_evt (lock_evt)
    );

    rngf_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ie_we   (bus_we && bus_addr == A_IE),
        .is_we   (bus_we && bus_addr == A_IS),
        .glob_wr (bus_wdata[31]),
        .src_wr  (bus_wdata[NSRC-1:0]),
        .set_vec (set_vec),
        .ie_glob (ie_glob),
        .ie_src  (ie_src),
        .is_vec  (is_vec),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr >= A_DATA && bus_addr < A_DATA + 8'(4 * NWORDS))
            bus_rdata = st_q.data[bus_addr[IDX_W+1:2]];
        else begin
            unique case (bus_addr)
                A_STAT:  bus_rdata[9] = st_q.seeded;
                A_MODE:  bus_rdata[3] = st_q.len256;
                A_IE:    bus_rdata = {ie_glob, {(31-NSRC){1'b0}}, ie_src};
                A_IS:    bus_rdata = {{(32-NSRC){1'b0}}, is_vec};
                A_BLD:   bus_rdata = BUILD_WORD;
                A_FEAT:  bus_rdata = FEATURE_WORD;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rngf_chk.sv
module rngf_chk
    import rngf_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int MAXC  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             ie_glob,
    input logic             seeded,
    input logic [CNT_W-1:0] cnt,
    input logic [NSRC-1:0]  is_vec,
    input logic [31:0]      lfsr_state
);
    // R10
    irq_glob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie_glob);
    // R3
    seeded_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seeded |=> seeded);
    // R8
    busy_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAXC));
    // R7
    req_unseeded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_vec[SRC_REQ]) |-> !seeded);
    // R4
    rdy_seeded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_vec[SRC_RDY]) |-> seeded);
    // R11
    lock_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lfsr_state == '0) |=> (lfsr_state != '0) && is_vec[SRC_LOCK]);
endmodule

bind rng_regfront rngf_chk #(.CNT_W(CNT_W), .MAXC(RESEED_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .ie_glob    (ie_glob),
    .seeded     (st_q.seeded),
    .cnt        (st_q.cnt),
    .is_vec     (is_vec),
    .lfsr_state (lfsr_state)
);

// File: tb/sim_rng_regfront.sv
module sim_rng_regfront;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] seed_in = '0;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rng_regfront u0 (.*);

    typedef struct packed {
        logic [7:0]  a;
        logic        we;
        logic [31:0] d;
    } vec_t;

    // writes carry data, reads carry the expected value (R6, R10, R12)
    localparam vec_t VT [14] = '{
        '{8'h10, 1'b1, 32'h8000_001F},
        '{8'h10, 1'b0, 32'h8000_001F},
        '{8'h10, 1'b1, 32'hFFFF_FFFF},
        '{8'h10, 1'b0, 32'h8000_001F},
        '{8'h08, 1'b1, 32'hFFFF_FFFF},
        '{8'h08, 1'b0, 32'h0000_0008},
        '{8'h1C, 1'b0, 32'h0000_000D},
        '{8'h18, 1'b0, 32'h0000_0038},
        '{8'h40, 1'b0, 32'h0000_0000},
        '{8'h04, 1'b0, 32'h0000_0000},
        '{8'h10, 1'b1, 32'h0000_0000},
        '{8'h10, 1'b0, 32'h0000_0000},
        '{8'h08, 1'b1, 32'h0000_0000},
        '{8'h08, 1'b0, 32'h0000_0000}
    };

    function automatic logic [31:0] stp(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [31:0] stpn(input logic [31:0] s, input int n);
        logic [31:0] x = s;
        for (int k = 0; k < n; k++) x = stp(x);
        return x;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // caller stands at a falling edge; capture happens on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_words(input string tag, input logic [31:0] exp [8]);
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            peek(8'h20 + 8'(4 * i), v);
            check(tag, v, exp[i]);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] st;
        logic [31:0] w [8];

        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(8'h04, v); check("R1 stat", v, 0);
        peek(8'h14, v); check("R1 istat", v, 0);
        peek(8'h10, v); check("R1 ienable", v, 0);
        peek(8'h08, v); check("R1 mode", v, 0);
        peek(8'h20, v); check("R1 word0", v, 0);
        peek(8'h3C, v); check("R1 word7", v, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // table walk: R6 mode readback, R10 enable readback, R12 constants
        foreach (VT[i]) begin
            if (VT[i].we) wr(VT[i].a, VT[i].d);
            else begin
                peek(VT[i].a, v);
                check($sformatf("R12 table row %0d", i), v, VT[i].d);
            end
        end

        // R7 request while unseeded
        wr(8'h00, 32'h1);
        peek(8'h14, v); check("R7 request lockup", v, 32'h08);
        cycles(6);
        peek(8'h14, v); check("R7 no random ready", v, 32'h08);
        wr(8'h14, 32'h08);
        peek(8'h14, v); check("R9 clear request lockup", v, 0);

        // R3 reseed timing, R8 command during busy ignored, R2 code 2
        seed_in = 32'h1234_5678;
        wr(8'h00, 32'h2);
        wr(8'h00, 32'h3);
        cycles(5);
        peek(8'h04, v); check("R3 not seeded at edge 6", v, 0);
        cycles(1);
        peek(8'h04, v); check("R3 not seeded at edge 7", v, 0);
        peek(8'h14, v); check("R3 no seed done at edge 7", v, 0);
        cycles(1);
        peek(8'h04, v); check("R3 seeded at edge 8", v, 32'h200);
        peek(8'h14, v); check("R3 seed done", v, 32'h02);
        st = 32'h1234_5678;

        // R4/R5 full-length output
        wr(8'h08, 32'h8);
        wr(8'h00, 32'h1);
        cycles(3);
        peek(8'h14, v); check("R4 not ready at edge 3", v, 32'h02);
        cycles(1);
        peek(8'h14, v); check("R4 ready at edge 4", v, 32'h03);
        for (int i = 0; i < 8; i++) w[i] = stpn(st, i + 1);
        check_words("R5 R8 words 256", w);
        st = stpn(st, 8);

        // R10 interrupt output
        wr(8'h10, 32'h8000_0001);
        check("R10 irq on", {31'b0, irq}, 1);
        wr(8'h10, 32'h0000_0001);
        check("R10 irq no global", {31'b0, irq}, 0);
        wr(8'h10, 32'h8000_0010);
        check("R10 irq other source", {31'b0, irq}, 0);
        wr(8'h10, 32'h8000_0002);
        check("R10 irq seed done", {31'b0, irq}, 1);
        wr(8'h14, 32'h03);
        peek(8'h14, v); check("R9 clear both", v, 0);
        check("R10 irq after clear", {31'b0, irq}, 0);

        // R6 short output: words 4..7 keep old values
        wr(8'h08, 32'h0);
        wr(8'h00, 32'h1);
        cycles(4);
        for (int i = 0; i < 4; i++) w[i] = stpn(st, i + 1);
        check_words("R6 words 128", w);
        st = stpn(st, 4);

        // R9 hardware set wins over clear on the same edge
        wr(8'h14, 32'h1F);
        wr(8'h00, 32'h1);
        cycles(3);
        wr(8'h14, 32'h01);
        peek(8'h14, v); check("R9 set wins over clear", v, 32'h01);
        for (int i = 0; i < 4; i++) w[i] = stpn(st, i + 1);
        check_words("R6 second short output", w);
        st = stpn(st, 4);

        // R2 no-op command
        wr(8'h14, 32'h1F);
        wr(8'h00, 32'h0);
        cycles(12);
        peek(8'h14, v); check("R2 nop istat", v, 0);
        peek(8'h04, v); check("R2 nop stat", v, 32'h200);

        // R11 nonce reseed giving a zero state
        seed_in = 32'h5A5A_5A5A;
        wr(8'h00, 32'h3);
        cycles(7);
        peek(8'h14, v); check("R11 before completion", v, 0);
        cycles(1);
        peek(8'h14, v); check("R11 seed done only", v, 32'h02);
        cycles(1);
        peek(8'h14, v); check("R11 lockup flagged", v, 32'h12);
        wr(8'h08, 32'h8);
        wr(8'h00, 32'h1);
        cycles(4);
        for (int i = 0; i < 8; i++) w[i] = stpn(32'h1, i + 1);
        check_words("R11 words from forced state", w);

        // R1 reset mid-run
        rst_n = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        @(negedge clk);
        peek(8'h04, v); check("R1 stat after reset", v, 0);
        peek(8'h14, v); check("R1 istat after reset", v, 0);
        peek(8'h24, v); check("R1 word1 after reset", v, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule